// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Controller

This block is the interrupt logic of one peripheral on a chain of devices that share a single active-low interrupt line. Each device passes an enable signal to the next, lower-priority device. The block collects interrupt causes from two serial channels and raises the shared request. When the processor acknowledges, the block places an 8-bit vector on the bus if it is the highest-priority requester. It then keeps its own under-service latch set until the interrupt routine returns.

The block watches every opcode fetch for the two-byte return-from-interrupt sequence. It also accepts a one-cycle software return command, which has the same effect. In the cause-coded mode, three bits of the programmed vector are replaced with a code for the most urgent pending cause. Interrupt status is held frozen for as long as the machine-cycle-one strobe is low, so the chain stays stable while the processor resolves priority.

Top module: `dc_irq_chain`

## Requirements
- R1: After reset, `int_n` is high, `vec_oe` is low, the under-service latch is clear, and `ieo` equals `ien`.
- R2: `ieo` equals `ien` when no cause is pending, the device is not under service, and no return prefix is outstanding. In any other case `ieo` is low.
- R3: `int_n` is low whenever at least one cause is pending and the device is not under service. Otherwise `int_n` is high.
- R4: The pending cause set samples the request inputs only in cycles where `m1_n` is high. While `m1_n` is low, the set holds its value.
- R5: An acknowledge is a cycle in which `m1_n` and `iorq_n` are both low. If `ien` is high, a cause is pending and the device is not under service, that cycle drives `vec_oe` high and sets the under-service latch at its clock edge. After that, `int_n` is high and `ieo` is low.
- R6: An acknowledge cycle with `ien` low does not drive the vector and does not set the under-service latch.
- R7: With `sav_en` low, `vec_out` equals `vec_base`.
- R8: With `sav_en` high, `vec_out` bits 3:1 carry the cause code and the other bits come from `vec_base`. Causes are ranked from highest to lowest as follows, with their codes:
  - channel A special 111, channel A receive 110, channel A transmit 100, channel A status 101;
  - channel B special 011, channel B receive 010, channel B transmit 000, channel B status 001.
  Index 0 of each request vector is channel A.
- R9: The under-service latch clears if fetch 0xED is followed by fetch 0x4D, with `ien` high when the second fetch completes. A fetch is a `m1_n` low window with `iorq_n` high throughout; its byte is evaluated when `m1_n` rises.
- R10: The under-service latch stays set in three cases: after 0xED followed by any byte other than 0x4D; after 0x4D alone; and after the 0xED 0x4D pair if `ien` is low.
- R11: After a fetch of 0xED completes, `ieo` is held low until the next fetch completes.
- R12: A one-cycle `sw_ret` pulse with `ien` high clears the under-service latch, exactly as the snooped return sequence does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rx | input | NCH | Receive-character cause per channel |
| req_tx | input | NCH | Transmit-empty cause per channel |
| req_ext | input | NCH | External-status cause per channel |
| req_spec | input | NCH | Special-receive-condition cause per channel |
| ien | input | 1 | Enable from the higher-priority neighbour |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| bus_in | input | 8 | Data bus as seen during fetch |
| sw_ret | input | 1 | Software return-from-interrupt command pulse |
| sav_en | input | 1 | Cause-coded vector mode |
| vec_base | input | 8 | Programmed interrupt vector |
| int_n | output | 1 | Shared interrupt request, active low |
| ieo | output | 1 | Enable to the lower-priority neighbour |
| vec_out | output | 8 | Vector presented during acknowledge |
| vec_oe | output | 1 | Vector drive enable |

## Verification
The bench looks for priority faults with pairs of causes that straddle the two channels, and with the special-condition and receive pair. An encoder with a wrong ranking or a swapped code returns a different vector. Return sequences are tested when incomplete, out of order, and when they arrive with the enable input low. A snooper that matches a single byte, or ignores the chain position, would clear the latch too early and release `ieo`. Requests that change while `m1_n` is low must leave `int_n` unchanged until `m1_n` rises; a design that does not freeze its status moves the request line during the window. The bench also confirms that `ieo` stays low for exactly one fetch after a lone 0xED prefix.

// File: rtl/dc_irq_pkg.sv
package dc_irq_pkg;

    localparam int BUS_W = 8;
    localparam logic [BUS_W-1:0] OP_PREFIX = 8'hED;
    localparam logic [BUS_W-1:0] OP_RET    = 8'h4D;

    // Per-channel cause kinds (low two bits of the cause code)
    localparam logic [1:0] K_TX   = 2'b00;
    localparam logic [1:0] K_EXT  = 2'b01;
    localparam logic [1:0] K_RX   = 2'b10;
    localparam logic [1:0] K_SPEC = 2'b11;

    typedef enum logic [0:0] {
        SN_IDLE   = 1'b0,
        SN_GOT_ED = 1'b1
    } snoop_e;

    typedef struct packed {
        snoop_e           st;
        logic             in_m1;
        logic             ack_seen;
        logic [BUS_W-1:0] opc;
    } snoop_t;

endpackage

// File: rtl/dc_cause_pri.sv
module dc_cause_pri
    import dc_irq_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = $clog2(NCH) + 2
) (
    input  logic [NCH-1:0] rx,
    input  logic [NCH-1:0] tx,
    input  logic [NCH-1:0] ext,
    input  logic [NCH-1:0] spec,
    output logic [CW-1:0]  code,
    output logic           any
);
    localparam int CHW = CW - 2;

    // Walk from lowest to highest priority; the last match wins.
    always_comb begin
        any  = 1'b0;
        code = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (ext[c]) begin
                any  = 1'b1;
                code = {CHW'(NCH - 1 - c), K_EXT};
            end
            if (tx[c]) begin
                any  = 1'b1;
                code = {CHW'(NCH - 1 - c), K_TX};
            end
            if (rx[c]) begin
                any  = 1'b1;
                code = {CHW'(NCH - 1 - c), K_RX};
            end
            if (spec[c]) begin
                any  = 1'b1;
                code = {CHW'(NCH - 1 - c), K_SPEC};
            end
        end
    end

endmodule

// File: rtl/dc_vec_mux.sv
module dc_vec_mux #(
    parameter int VW = 8,
    parameter int CW = 3
) (
    input  logic [VW-1:0] base,
    input  logic [CW-1:0] code,
    input  logic          sav,
    output logic [VW-1:0] vec
);
    for (genvar i = 0; i < VW; i++) begin : g_bit
        if (i >= 1 && i <= CW) begin : g_sub
            assign vec[i] = sav ? code[i-1] : base[i];
        end else begin : g_keep
            assign vec[i] = base[i];
        end
    end

endmodule

// File: rtl/dc_fetch_snoop.sv
module dc_fetch_snoop
    import dc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m1_n,
    input  logic             iorq_n,
    input  logic [BUS_W-1:0] bus_in,
    output logic             ret_pulse,
    output logic             prefix_hold
);
    snoop_t s_q, s_d;
    logic   fetch_active;
    logic   fetch_done;

    always_comb begin
        s_d          = s_q;
        fetch_active = !m1_n && iorq_n;
        fetch_done   = s_q.in_m1 && m1_n && !s_q.ack_seen;
        ret_pulse    = 1'b0;

        s_d.in_m1    = !m1_n;
        s_d.ack_seen = !m1_n && (s_q.ack_seen || !iorq_n);
        if (fetch_active) begin
            s_d.opc = bus_in;
        end

        if (fetch_done) begin
            if (s_q.opc == OP_PREFIX) begin
                s_d.st = SN_GOT_ED;
            end else begin
                if (s_q.st == SN_GOT_ED && s_q.opc == OP_RET) begin
                    ret_pulse = 1'b1;
                end
                s_d.st = SN_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SN_IDLE, in_m1: 1'b0, ack_seen: 1'b0, opc: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign prefix_hold = (s_q.st == SN_GOT_ED);

endmodule

// File: rtl/dc_irq_chain.sv
module dc_irq_chain
    import dc_irq_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req_rx,
    input  logic [NCH-1:0]   req_tx,
    input  logic [NCH-1:0]   req_ext,
    input  logic [NCH-1:0]   req_spec,
    input  logic             ien,
    input  logic             m1_n,
    input  logic             iorq_n,
    input  logic [BUS_W-1:0] bus_in,
    input  logic             sw_ret,
    input  logic             sav_en,
    input  logic [BUS_W-1:0] vec_base,
    output logic             int_n,
    output logic             ieo,
    output logic [BUS_W-1:0] vec_out,
    output logic             vec_oe
);
    localparam int CW = $clog2(NCH) + 2;

    typedef struct packed {
        logic [NCH-1:0] rx;
        logic [NCH-1:0] tx;
        logic [NCH-1:0] ext;
        logic [NCH-1:0] spec;
        logic           ius;
    } chain_t;

    chain_t          s_q, s_d;
    logic            any_pend;
    logic [CW-1:0]   code;
    logic            snoop_ret;
    logic            prefix_hold;
    logic            ack;
    logic            ret_evt;
    logic [4*NCH-1:0] pend_all;

    dc_cause_pri #(.NCH(NCH), .CW(CW)) u_pri (
        .rx   (s_q.rx),
        .tx   (s_q.tx),
        .ext  (s_q.ext),
        .spec (s_q.spec),
        .code (code),
        .any  (any_pend)
    );

    dc_fetch_snoop u_snoop (
        .clk         (clk),
        .rst_n       (rst_n),
        .m1_n        (m1_n),
        .iorq_n      (iorq_n),
        .bus_in      (bus_in),
        .ret_pulse   (snoop_ret),
        .prefix_hold (prefix_hold)
    );

    dc_vec_mux #(.VW(BUS_W), .CW(CW)) u_vmux (
        .base (vec_base),
        .code (code),
        .sav  (sav_en),
        .vec  (vec_out)
    );

    always_comb begin
        s_d     = s_q;
        ack     = !m1_n && !iorq_n && ien && any_pend && !s_q.ius;
        ret_evt = (snoop_ret || sw_ret) && ien && s_q.ius;

        // Status is frozen during the whole M1-low window
        if (m1_n) begin
            s_d.rx   = req_rx;
            s_d.tx   = req_tx;
            s_d.ext  = req_ext;
            s_d.spec = req_spec;
        end

        if (ack) begin
            s_d.ius = 1'b1;
        end else if (ret_evt) begin
            s_d.ius = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign int_n    = !(any_pend && !s_q.ius);
    assign ieo      = ien && !any_pend && !s_q.ius && !prefix_hold;
    assign vec_oe   = ack;
    assign pend_all = {s_q.spec, s_q.rx, s_q.tx, s_q.ext};

endmodule

// File: rtl/dc_irq_chain_chk.sv
module dc_irq_chain_chk #(
    parameter int NCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ien,
    input logic             m1_n,
    input logic             iorq_n,
    input logic             int_n,
    input logic             ieo,
    input logic             vec_oe,
    input logic [4*NCH-1:0] pend_all
);
    // R2
    ieo_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !ieo);

    // R2
    ieo_low_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> !ieo);

    // R4
    status_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m1_n |=> $stable(pend_all));

    // R5
    drive_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (!m1_n && !iorq_n));

    // R5
    served_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |=> (int_n && !ieo));

    // R6
    no_drive_unenabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !vec_oe);

endmodule

bind dc_irq_chain dc_irq_chain_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ien      (ien),
    .m1_n     (m1_n),
    .iorq_n   (iorq_n),
    .int_n    (int_n),
    .ieo      (ieo),
    .vec_oe   (vec_oe),
    .pend_all (pend_all)
);

// File: tb/sim_dc_irq_chain.sv
module sim_dc_irq_chain;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req_rx = '0, req_tx = '0, req_ext = '0, req_spec = '0;
    logic       ien = 1'b1;
    logic       m1_n = 1'b1;
    logic       iorq_n = 1'b1;
    logic [7:0] bus_in = '0;
    logic       sw_ret = 1'b0;
    logic       sav_en = 1'b0;
    logic [7:0] vec_base = 8'h71;
    logic       int_n, ieo, vec_oe;
    logic [7:0] vec_out;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    dc_irq_chain #(.NCH(2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_rx(req_rx), .req_tx(req_tx), .req_ext(req_ext), .req_spec(req_spec),
        .ien(ien), .m1_n(m1_n), .iorq_n(iorq_n), .bus_in(bus_in),
        .sw_ret(sw_ret), .sav_en(sav_en), .vec_base(vec_base),
        .int_n(int_n), .ieo(ieo), .vec_out(vec_out), .vec_oe(vec_oe)
    );

    // Entry: rx[16:15] tx[14:13] ext[12:11] spec[10:9] sav[8] vec[7:0]; bit0 = channel A
    localparam int NV = 10;
    localparam logic [16:0] TBL [NV] = '{
        {2'b01, 2'b00, 2'b00, 2'b00, 1'b1, 8'h7D},
        {2'b10, 2'b01, 2'b00, 2'b00, 1'b1, 8'h79},
        {2'b00, 2'b00, 2'b10, 2'b00, 1'b1, 8'h73},
        {2'b00, 2'b10, 2'b01, 2'b00, 1'b1, 8'h7B},
        {2'b01, 2'b00, 2'b00, 2'b01, 1'b1, 8'h7F},
        {2'b00, 2'b10, 2'b10, 2'b00, 1'b1, 8'h71},
        {2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 8'h71},
        {2'b10, 2'b00, 2'b00, 2'b00, 1'b1, 8'h75},
        {2'b00, 2'b00, 2'b00, 2'b10, 1'b1, 8'h77},
        {2'b10, 2'b00, 2'b01, 2'b00, 1'b1, 8'h7B}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_ack(output logic oe, output logic [7:0] v);
        @(negedge clk) m1_n = 1'b0;
        @(negedge clk) iorq_n = 1'b0;
        #2;
        oe = vec_oe;
        v  = vec_out;
        @(negedge clk);
        m1_n   = 1'b1;
        iorq_n = 1'b1;
        #1;
    endtask

    task automatic fetch(input logic [7:0] b);
        @(negedge clk);
        m1_n   = 1'b0;
        bus_in = b;
        @(negedge clk) m1_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_ret;
        @(negedge clk) sw_ret = 1'b1;
        @(negedge clk) sw_ret = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       oe;
        logic [7:0] v;

        idle(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 int_n", {7'd0, int_n}, 8'd1);
        chk("R1 vec_oe", {7'd0, vec_oe}, 8'd0);
        chk("R1 ieo", {7'd0, ieo}, 8'd1);

        // Table of cause patterns: R3, R5, R7, R8, R12
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            req_rx   = TBL[k][16:15];
            req_tx   = TBL[k][14:13];
            req_ext  = TBL[k][12:11];
            req_spec = TBL[k][10:9];
            sav_en   = TBL[k][8];
            idle(2);
            #1;
            chk("R3 request", {7'd0, int_n}, 8'd0);
            do_ack(oe, v);
            chk("R5 drive", {7'd0, oe}, 8'd1);
            chk(TBL[k][8] ? "R8 coded vector" : "R7 plain vector", v, TBL[k][7:0]);
            chk("R5 served int_n", {7'd0, int_n}, 8'd1);
            chk("R5 served ieo", {7'd0, ieo}, 8'd0);
            @(negedge clk);
            req_rx = '0; req_tx = '0; req_ext = '0; req_spec = '0;
            pulse_ret();
            @(negedge clk);
            #1;
            chk("R12 sw return", {7'd0, ieo}, 8'd1);
        end

        // R2 enable passes through
        @(negedge clk) ien = 1'b0;
        #1;
        chk("R2 ieo follows ien", {7'd0, ieo}, 8'd0);

        // R6 acknowledge with ien low
        @(negedge clk) req_rx = 2'b01;
        idle(2);
        do_ack(oe, v);
        chk("R6 no drive", {7'd0, oe}, 8'd0);
        chk("R6 no latch", {7'd0, int_n}, 8'd0);
        @(negedge clk) ien = 1'b1;

        // R9 snooped return pair
        do_ack(oe, v);
        @(negedge clk) req_rx = '0;
        idle(1);
        #1;
        chk("R9 in service", {7'd0, ieo}, 8'd0);
        fetch(8'hED);
        fetch(8'h4D);
        chk("R9 pair clears", {7'd0, ieo}, 8'd1);

        // R10 non-matching sequences
        @(negedge clk) req_tx = 2'b10;
        idle(2);
        do_ack(oe, v);
        @(negedge clk) req_tx = '0;
        fetch(8'h4D);
        chk("R10 lone 4D", {7'd0, ieo}, 8'd0);
        fetch(8'hED);
        fetch(8'h00);
        chk("R10 ED then 00", {7'd0, ieo}, 8'd0);
        @(negedge clk) ien = 1'b0;
        fetch(8'hED);
        fetch(8'h4D);
        @(negedge clk) ien = 1'b1;
        #1;
        chk("R10 pair with ien low", {7'd0, ieo}, 8'd0);
        pulse_ret();
        chk("R12 sw return clears", {7'd0, ieo}, 8'd1);

        // R11 prefix holds ieo for one fetch
        fetch(8'hED);
        chk("R11 prefix hold", {7'd0, ieo}, 8'd0);
        fetch(8'h00);
        chk("R11 release", {7'd0, ieo}, 8'd1);

        // R4 freeze while m1_n low
        @(negedge clk);
        m1_n   = 1'b0;
        bus_in = 8'h00;
        req_tx = 2'b01;
        idle(2);
        #1;
        chk("R4 frozen int_n", {7'd0, int_n}, 8'd1);
        @(negedge clk) m1_n = 1'b1;
        idle(1);
        #1;
        chk("R4 released int_n", {7'd0, int_n}, 8'd0);
        @(negedge clk) req_tx = '0;
        idle(2);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule